// File: doc/BRIEF.md
# Reed-Solomon Symbol Correction Writer

This block sits behind a Reed-Solomon decoder that works on 12-bit symbols. It applies the decoder's error list to a byte buffer that holds a 2048-byte page followed by its spare bytes. Each list entry carries a symbol position and a 12-bit error pattern. Because a symbol spans one and a half bytes, the block turns each position into one or two byte addresses with byte masks. It then XORs the masks into the buffer through a single synchronous RAM port by reading and then writing each byte.

The buffer is addressed as one flat array. Page byte k is at address k and spare byte k is at address 2048 + k. With that layout, the symbol that straddles the page and spare boundary, and the symbols that lie wholly in the spare area, need no special addressing. Entries arrive on a valid/ready stream, one page's list at a time, and the final entry is flagged. At the end of a page the block pulses `done` and reports either the number of corrected symbols or a failure.

Back-pressure rules: `err_ready` is high only while the block is idle. An entry transfers on a clock edge where `err_valid` and `err_ready` are both high. The source must hold the entry stable while `err_valid` is high and `err_ready` is low. After each transfer, `err_ready` stays low until that entry's read-modify-write work is finished. It also stays low for one further cycle after the flagged final entry.

Top module: `rs_fix_mapper`

## Requirements
- R1: `err_ready` is 1 only while the block is idle, with no RAM access in progress. It drops in the cycle after an entry that needs buffer work is accepted, and exactly one entry is taken per handshake.
- R2: At position 0, a pattern of 0xFF or less XORs its low 8 bits into address 0 and writes no other byte.
- R3: At position 0, a pattern above 0xFF (any of bits 11..8 set) is a failure, and the entry writes nothing.
- R4: At an odd position p, address (3p-1)/2 is XORed with pattern bits 11..4. The following address is XORed with pattern bits 3..0 placed in its upper nibble, with the lower nibble 0.
- R5: At an even position p of 2 or more, address 3p/2-1 is XORed with pattern bits 11..8 in its lower nibble (upper nibble 0), and address 3p/2 with pattern bits 7..0.
- R6: Position 1365 writes page byte 2047 (address 2047) with pattern bits 11..4, and spare byte 0 (address 2048) with pattern bits 3..0 in its upper nibble.
- R7: Positions 1366 to 1374 follow the rules of R4 and R5 and land in the spare area, at address 2048 plus the spare offset.
- R8: A position above 1374 is a failure, and the entry writes nothing.
- R9: At most 4 entries of a page are applied. A fifth entry that would otherwise be valid is a failure.
- R10: After the first failure in a page, that entry and every later entry of the page write nothing. Entries applied earlier in the page remain in the buffer.
- R11: `done` is a single-cycle pulse that follows the flagged final entry. In the `done` cycle, `fail` shows whether the page failed, and `corr_count` shows the number of applied entries, or 0 on failure. Both hold until the next `done`. Each page starts from a zero count.
- R12: The RAM port reads a byte (`mem_en`=1, `mem_we`=0), expects the data one cycle later, and in that next cycle writes the same address with the data XOR the mask. The port makes at most one access per cycle.
- R13: After reset, `err_ready`=1, `mem_en`=0, `done`=0, `fail`=0 and `corr_count`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| err_valid | input | 1 | Error entry valid |
| err_ready | output | 1 | Block can accept an entry |
| err_pos | input | 12 | Symbol position of the entry |
| err_pat | input | 12 | Error pattern of the entry |
| err_last | input | 1 | Entry is the final one of the page |
| mem_en | output | 1 | RAM access strobe |
| mem_we | output | 1 | RAM write enable (read when 0) |
| mem_addr | output | 12 | RAM byte address |
| mem_wdata | output | 8 | RAM write data |
| mem_rdata | input | 8 | RAM read data, one cycle after the read |
| done | output | 1 | Page result pulse |
| fail | output | 1 | Page was uncorrectable |
| corr_count | output | 3 | Number of corrected symbols |

## Verification
The bench targets positions 0, 1365, 1374 and 1375. A mapper with off-by-one address arithmetic would write the wrong byte at these positions, or write a byte just outside the valid range. A 0x100 pattern at position 0 tests whether the block wrongly keeps only the low byte instead of failing. Pages with a failure in the middle and pages with a fifth entry check that earlier corrections survive and that later entries write nothing; a design with a non-sticky failure would apply those later entries. A symbol corrected twice in one page must cancel out, which exposes a write that lands in the wrong cycle or reads stale data.

// File: rtl/rsfix_pkg.sv
package rsfix_pkg;
  localparam int SYM_W  = 12;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2,
    ST_FIN   = 2'd3
  } rmw_state_e;
endpackage

// File: rtl/rsfix_locate.sv
// Maps a symbol position and pattern onto one or two flat buffer bytes.
module rsfix_locate
  import rsfix_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int MAX_POS = 1374
) (
  input  logic [SYM_W-1:0]  pos,
  input  logic [SYM_W-1:0]  pat,
  output logic [ADDR_W-1:0] addr_lo,
  output logic [ADDR_W-1:0] addr_hi,
  output logic [BYTE_W-1:0] mask_lo,
  output logic [BYTE_W-1:0] mask_hi,
  output logic              two_bytes,
  output logic              bad
);
  localparam int TW = SYM_W + 1;

  logic [SYM_W-1:0] half;
  logic [TW-1:0]    triple;

  // 3 * floor(pos/2), the byte where the symbol pair starts
  assign half   = pos >> 1;
  assign triple = {1'b0, half} + {half, 1'b0};

  always_comb begin
    two_bytes = 1'b1;
    bad       = (int'(pos) > MAX_POS);
    addr_lo   = '0;
    addr_hi   = '0;
    mask_lo   = '0;
    mask_hi   = '0;
    if (pos == '0) begin
      // first symbol carries only eight data bits
      two_bytes = 1'b0;
      mask_lo   = pat[7:0];
      if (pat[SYM_W-1:8] != '0) bad = 1'b1;
    end else if (pos[0]) begin
      addr_lo = ADDR_W'(triple + TW'(1));
      addr_hi = ADDR_W'(triple + TW'(2));
      mask_lo = pat[SYM_W-1:4];
      mask_hi = {pat[3:0], 4'h0};
    end else begin
      addr_lo = ADDR_W'(triple - TW'(1));
      addr_hi = ADDR_W'(triple);
      mask_lo = {4'h0, pat[SYM_W-1:8]};
      mask_hi = pat[7:0];
    end
  end
endmodule

// File: rtl/rsfix_tally.sv
// Per-page bookkeeping of applied entries and sticky failure.
module rsfix_tally #(
  parameter int MAX_ERR = 4,
  parameter int CNT_W   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic             bad_entry,
  input  logic             fin,
  output logic             drop,
  output logic             done,
  output logic             res_fail,
  output logic [CNT_W-1:0] res_count
);
  logic [CNT_W-1:0] count_q;
  logic             failed_q;

  assign drop = bad_entry || failed_q || (int'(count_q) == MAX_ERR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q   <= '0;
      failed_q  <= 1'b0;
      done      <= 1'b0;
      res_fail  <= 1'b0;
      res_count <= '0;
    end else begin
      done <= 1'b0;
      if (fin) begin
        done      <= 1'b1;
        res_fail  <= failed_q;
        res_count <= failed_q ? '0 : count_q;
        count_q   <= '0;
        failed_q  <= 1'b0;
      end else if (take) begin
        if (drop) failed_q <= 1'b1;
        else      count_q  <= count_q + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/rsfix_rmw.sv
// Sequences read-then-write of each affected byte over one RAM port.
module rsfix_rmw
  import rsfix_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              last,
  input  logic              drop,
  input  logic              two_bytes,
  input  logic [ADDR_W-1:0] addr_lo,
  input  logic [ADDR_W-1:0] addr_hi,
  input  logic [BYTE_W-1:0] mask_lo,
  input  logic [BYTE_W-1:0] mask_hi,
  output logic              ready,
  output logic              fin,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [BYTE_W-1:0] mem_wdata,
  input  logic [BYTE_W-1:0] mem_rdata
);
  rmw_state_e        state;
  logic              sel;
  logic              two_q;
  logic              last_q;
  logic [ADDR_W-1:0] addr_q [2];
  logic [BYTE_W-1:0] mask_q [2];

  assign ready     = (state == ST_IDLE);
  assign fin       = (state == ST_FIN);
  assign mem_en    = (state == ST_READ) || (state == ST_WRITE);
  assign mem_we    = (state == ST_WRITE);
  assign mem_addr  = addr_q[sel];
  assign mem_wdata = mem_rdata ^ mask_q[sel];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      sel    <= 1'b0;
      two_q  <= 1'b0;
      last_q <= 1'b0;
      for (int i = 0; i < 2; i++) begin
        addr_q[i] <= '0;
        mask_q[i] <= '0;
      end
    end else begin
      unique case (state)
        ST_IDLE: if (take) begin
          last_q <= last;
          if (drop) begin
            state <= last ? ST_FIN : ST_IDLE;
          end else begin
            addr_q[0] <= addr_lo;
            addr_q[1] <= addr_hi;
            mask_q[0] <= mask_lo;
            mask_q[1] <= mask_hi;
            two_q     <= two_bytes;
            sel       <= 1'b0;
            state     <= ST_READ;
          end
        end
        ST_READ: state <= ST_WRITE;
        ST_WRITE: begin
          if (!sel && two_q) begin
            sel   <= 1'b1;
            state <= ST_READ;
          end else begin
            state <= last_q ? ST_FIN : ST_IDLE;
          end
        end
        ST_FIN: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rs_fix_mapper.sv
module rs_fix_mapper #(
  parameter int PAGE_BYTES  = 2048,
  parameter int SPARE_BYTES = 64,
  parameter int MAX_POS     = 1374,
  parameter int MAX_ERR     = 4,
  localparam int BUF_BYTES  = PAGE_BYTES + SPARE_BYTES,
  localparam int ADDR_W     = $clog2(BUF_BYTES),
  localparam int CNT_W      = $clog2(MAX_ERR + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              err_valid,
  output logic              err_ready,
  input  logic [11:0]       err_pos,
  input  logic [11:0]       err_pat,
  input  logic              err_last,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata,
  output logic              done,
  output logic              fail,
  output logic [CNT_W-1:0]  corr_count
);
  logic [ADDR_W-1:0] addr_lo, addr_hi;
  logic [7:0]        mask_lo, mask_hi;
  logic              two_bytes, bad, drop, take, fin;

  assign take = err_valid && err_ready;

  rsfix_locate #(.ADDR_W(ADDR_W), .MAX_POS(MAX_POS)) u_locate (
    .pos(err_pos), .pat(err_pat),
    .addr_lo(addr_lo), .addr_hi(addr_hi),
    .mask_lo(mask_lo), .mask_hi(mask_hi),
    .two_bytes(two_bytes), .bad(bad)
  );

  rsfix_tally #(.MAX_ERR(MAX_ERR), .CNT_W(CNT_W)) u_tally (
    .clk(clk), .rst_n(rst_n), .take(take), .bad_entry(bad), .fin(fin),
    .drop(drop), .done(done), .res_fail(fail), .res_count(corr_count)
  );

  rsfix_rmw #(.ADDR_W(ADDR_W)) u_rmw (
    .clk(clk), .rst_n(rst_n), .take(take), .last(err_last), .drop(drop),
    .two_bytes(two_bytes), .addr_lo(addr_lo), .addr_hi(addr_hi),
    .mask_lo(mask_lo), .mask_hi(mask_hi),
    .ready(err_ready), .fin(fin),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );
endmodule

// File: rtl/rs_fix_mapper_chk.sv
module rs_fix_mapper_chk #(
  parameter int BUF_BYTES = 2112,
  parameter int ADDR_W    = 12,
  parameter int MAX_ERR   = 4,
  parameter int CNT_W     = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              err_ready,
  input logic              mem_en,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              done,
  input logic              fail,
  input logic [CNT_W-1:0]  corr_count
);
  a_r1_ready_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
    err_ready |-> !mem_en);

  a_r12_read_then_write: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && !mem_we) |=> (mem_en && mem_we));

  a_r12_write_same_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && mem_we) |-> ($past(mem_en && !mem_we) && mem_addr == $past(mem_addr)));

  a_r7_addr_in_buffer: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> (int'(mem_addr) < BUF_BYTES));

  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r11_fail_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fail) |-> (corr_count == '0));

  a_r9_count_limit: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (int'(corr_count) <= MAX_ERR));

  a_r11_result_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!done && !$past(!rst_n)) |-> ($stable(fail) && $stable(corr_count)));
endmodule

bind rs_fix_mapper rs_fix_mapper_chk #(
  .BUF_BYTES(BUF_BYTES), .ADDR_W(ADDR_W), .MAX_ERR(MAX_ERR), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .err_ready(err_ready), .mem_en(mem_en),
  .mem_we(mem_we), .mem_addr(mem_addr), .done(done), .fail(fail),
  .corr_count(corr_count)
);

// File: tb/rs_fix_mapper_test.sv
module rs_fix_mapper_test;
  localparam int BUF = 2112;
  localparam int NV  = 21;

  // {last, pos[12], pat[12], exp_fail, exp_count[3]}
  localparam logic [28:0] VEC [NV] = '{
    {1'b0, 12'd5,    12'hABC, 1'b0, 3'd0},  // R4
    {1'b0, 12'd6,    12'h123, 1'b0, 3'd0},  // R5
    {1'b1, 12'd1,    12'hFFF, 1'b0, 3'd3},
    {1'b0, 12'd0,    12'h0A5, 1'b0, 3'd0},  // R2
    {1'b0, 12'd1365, 12'h9C7, 1'b0, 3'd0},  // R6
    {1'b0, 12'd1366, 12'h456, 1'b0, 3'd0},  // R7
    {1'b1, 12'd1374, 12'h001, 1'b0, 3'd4},
    {1'b1, 12'd1367, 12'h3E1, 1'b0, 3'd1},  // R7 odd spare
    {1'b1, 12'd0,    12'h100, 1'b1, 3'd0},  // R3
    {1'b0, 12'd10,   12'h111, 1'b0, 3'd0},  // R10
    {1'b0, 12'd1375, 12'h222, 1'b0, 3'd0},  // R8
    {1'b1, 12'd12,   12'h333, 1'b1, 3'd0},
    {1'b0, 12'd2,    12'hA0A, 1'b0, 3'd0},  // R9
    {1'b0, 12'd3,    12'h0B0, 1'b0, 3'd0},
    {1'b0, 12'd4,    12'hC0C, 1'b0, 3'd0},
    {1'b0, 12'd7,    12'h0D0, 1'b0, 3'd0},
    {1'b1, 12'd9,    12'h555, 1'b1, 3'd0},
    {1'b1, 12'd1364, 12'h7E3, 1'b0, 3'd1},  // R5 below split
    {1'b1, 12'd8,    12'h0F0, 1'b0, 3'd1},  // R11 recovery
    {1'b0, 12'd20,   12'h5A5, 1'b0, 3'd0},  // R12 twice
    {1'b1, 12'd20,   12'h5A5, 1'b0, 3'd2}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        err_valid = 1'b0;
  logic        err_ready;
  logic [11:0] err_pos = '0;
  logic [11:0] err_pat = '0;
  logic        err_last = 1'b0;
  logic        mem_en, mem_we;
  logic [11:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = '0;
  logic        done, fail;
  logic [2:0]  corr_count;

  logic [7:0] ram     [BUF];
  logic [7:0] exp_mem [BUF];
  int checks = 0;
  int fails  = 0;
  int pcnt   = 0;
  int pfail  = 0;

  always #2 clk = ~clk;

  rs_fix_mapper uut (
    .clk(clk), .rst_n(rst_n), .err_valid(err_valid), .err_ready(err_ready),
    .err_pos(err_pos), .err_pat(err_pat), .err_last(err_last),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .done(done), .fail(fail), .corr_count(corr_count)
  );

  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) ram[mem_addr] <= mem_wdata;
      else        mem_rdata     <= ram[mem_addr];
    end
  end

  task automatic chk(input string req, input string what, input int act, input int expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // expected buffer update, written from the requirement text
  task automatic model(input int p, input int t);
    int b;
    if (pfail != 0 || p > 1374 || (p == 0 && t > 255) || pcnt == 4) begin
      pfail = 1;
    end else begin
      pcnt++;
      if (p == 0) begin
        exp_mem[0] = exp_mem[0] ^ 8'(t);
      end else if (p % 2 == 1) begin
        b = (3 * p - 1) / 2;
        exp_mem[b]   = exp_mem[b] ^ 8'(t >> 4);
        exp_mem[b+1] = exp_mem[b+1] ^ 8'((t & 15) << 4);
      end else begin
        b = 3 * p / 2;
        exp_mem[b-1] = exp_mem[b-1] ^ 8'(t >> 8);
        exp_mem[b]   = exp_mem[b] ^ 8'(t & 255);
      end
    end
  endtask

  task automatic send(input logic [11:0] p, input logic [11:0] t, input logic l);
    @(negedge clk);
    err_valid = 1'b1; err_pos = p; err_pat = t; err_last = l;
    while (!err_ready) @(negedge clk);
    @(posedge clk); #1;
    err_valid = 1'b0;
  endtask

  task automatic finish_page(input string req, input int efail, input int ecnt);
    int n = 0;
    int bad = 0;
    while (!done && n < 50) begin @(negedge clk); n++; end
    chk(req, "done seen", int'(done), 1);
    chk(req, "fail flag", int'(fail), efail);
    chk(req, "corr_count", int'(corr_count), ecnt);
    @(negedge clk);
    chk("R11", "done one cycle", int'(done), 0);
    for (int i = 0; i < BUF; i++) if (ram[i] !== exp_mem[i]) bad++;
    chk(req, "buffer mismatches", bad, 0);
    pcnt = 0; pfail = 0;
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < BUF; i++) begin
      ram[i]     = 8'(i * 37 + 11);
      exp_mem[i] = 8'(i * 37 + 11);
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R13 reset state
    chk("R13", "err_ready", int'(err_ready), 1);
    chk("R13", "mem_en", int'(mem_en), 0);
    chk("R13", "done", int'(done), 0);
    chk("R13", "fail", int'(fail), 0);
    chk("R13", "corr_count", int'(corr_count), 0);

    for (int v = 0; v < NV; v++) begin
      logic [28:0] e;
      e = VEC[v];
      model(int'(e[27:16]), int'(e[15:4]));
      send(e[27:16], e[15:4], e[28]);
      if (e[28]) finish_page($sformatf("R4-vector%0d", v), int'(e[3]), int'(e[2:0]));
    end

    // R1 and R12: back-pressure and port sequence for position 30 (bytes 44, 45)
    @(negedge clk);
    err_valid = 1'b1; err_pos = 12'd30; err_pat = 12'h0F0; err_last = 1'b1;
    chk("R1", "ready before transfer", int'(err_ready), 1);
    @(posedge clk); #1;
    err_valid = 1'b0;
    model(30, 'h0F0);
    @(negedge clk);
    chk("R1", "ready low while busy", int'(err_ready), 0);
    chk("R12", "read strobe", int'(mem_en && !mem_we), 1);
    chk("R12", "read addr", int'(mem_addr), 44);
    @(negedge clk);
    chk("R12", "write strobe", int'(mem_en && mem_we), 1);
    chk("R12", "write addr", int'(mem_addr), 44);
    finish_page("R1", 0, 1);
    repeat (3) @(negedge clk);
    chk("R11", "count held", int'(corr_count), 1);
    chk("R11", "fail held", int'(fail), 0);

    summary();
    $finish;
  end
endmodule